// File: doc/BRIEF.md
# Sampling Phase Window Search Engine

This block tunes the sampling point of a delay line that has already been calibrated. It is given the calibrated unit value and the highest usable tap phase. It then steps through every phase in turn. For each phase it programs the delay line and asks an external agent to run a pass/fail test. The longest unbroken stretch of passing phases is taken as the valid data eye. The phase at the centre of that stretch is programmed as the result.

A search begins with a one-cycle `start` pulse. Each phase is programmed in three cycles. First both enables are raised. Then the unit and phase fields are written. Then the sampler enable is dropped, leaving the delay active. After that, `test_req` is raised and held until the agent answers on `test_ack`. The `test_pass` bit is sampled in the cycle that `test_ack` is high.

When the sweep ends, the centre phase is programmed with the same three-cycle sequence, and `done` pulses. If no phase passed, `err` is raised together with `done`, and no final phase is programmed. A `bypass` input returns the line to pass-through at any time and aborts a search that is in progress.

Top module: `phase_window_search`

## Requirements
- R1: After reset, `dly_en`, `smp_en`, `test_req`, `done` and `err` are 0, and `cfg_phase`, `cfg_unit` and `final_phase` are 0.
- R2: A search tests the phases 0, 1, …, `max_phase_in` once each, in ascending order. Both inputs are captured at `start`. Every configuration write puts the captured unit value on `cfg_unit`.
- R3: Each phase is programmed in a fixed order. First `dly_en` and `smp_en` go to 1. Then `cfg_unit` and `cfg_phase` change while `smp_en` is 1. Then `smp_en` returns to 0. `test_req` is high only while `dly_en` is 1 and `smp_en` is 0. The configuration stays stable while `test_req` waits for `test_ack`.
- R4: A failing phase breaks the current run of passes, and a passing phase extends it. The longest run of consecutive passing phases is the one selected.
- R5: When two runs have the same length, the run that starts at the lower phase is selected.
- R6: The final phase is the last phase of the selected run minus floor(run length / 2). It is written with the R3 sequence, appears on `cfg_phase` and `final_phase`, and leaves `dly_en`=1 and `smp_en`=0.
- R7: If no phase passes, `err` rises in the same cycle as `done`, and `cfg_phase` keeps the last swept phase. `err` is cleared by the next `start`.
- R8: `done` is a single-cycle pulse, raised exactly once for each search that completes, and never while `test_req` is high.
- R9: While `bypass` is 1, from the next cycle on `dly_en`, `smp_en` and `test_req` are 0. A search in progress is abandoned without a `done`, and `start` is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a search (one-cycle pulse) |
| bypass | input | 1 | Force pass-through; clears both enables and aborts a search |
| unit_in | input | UNIT_W | Calibrated delay unit value |
| max_phase_in | input | PH_W | Highest phase to test |
| test_ack | input | 1 | Test result valid |
| test_pass | input | 1 | Test result, 1 = pass, sampled with `test_ack` |
| test_req | output | 1 | Request a pass/fail test at the programmed phase |
| dly_en | output | 1 | Delay line enable |
| smp_en | output | 1 | Sampler enable (high only while fields are written) |
| cfg_unit | output | UNIT_W | Programmed unit field |
| cfg_phase | output | PH_W | Programmed phase field |
| final_phase | output | PH_W | Chosen centre phase of the last successful search |
| done | output | 1 | Search complete pulse |
| err | output | 1 | No passing phase found in the last search |

## Verification
The assertions check the programming order on every cycle. They require that the sampler is never on without the delay, that fields change only while the sampler is on, and that the request is raised only after the sampler is released and holds the configuration stable until it is acknowledged. They also check that `done` is a one-cycle pulse, that `err` rises only together with `done`, and that `bypass` clears the line on the following cycle. The choice of the window can only be shown by the bench scenarios. These cover ascending phase order, the longest-run and tie rules, the arithmetic of the centre phase, and the behaviour when no phase passes. The bench checks each of these against an independent run scan, over every pass pattern for a five-phase sweep and over selected patterns for the full sixteen-phase range.

// File: rtl/phase_window_search.sv
module phase_window_search #(
  parameter int UNIT_W = 7,
  parameter int PH_W   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              bypass,
  input  logic [UNIT_W-1:0] unit_in,
  input  logic [PH_W-1:0]   max_phase_in,
  input  logic              test_ack,
  input  logic              test_pass,
  output logic              test_req,
  output logic              dly_en,
  output logic              smp_en,
  output logic [UNIT_W-1:0] cfg_unit,
  output logic [PH_W-1:0]   cfg_phase,
  output logic [PH_W-1:0]   final_phase,
  output logic              done,
  output logic              err
);
  localparam int LEN_W = PH_W + 1;

  typedef enum logic [2:0] {
    ST_IDLE, ST_EN, ST_WR, ST_REL, ST_TEST, ST_DECIDE
  } st_t;

  st_t              state;
  logic             fin;
  logic [UNIT_W-1:0] unit_r;
  logic [PH_W-1:0]  max_r, phase, best_end;
  logic [LEN_W-1:0] cur_len, best_len, cur_inc;

  assign cur_inc = cur_len + LEN_W'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state       <= ST_IDLE;
      fin         <= 1'b0;
      unit_r      <= '0;
      max_r       <= '0;
      phase       <= '0;
      best_end    <= '0;
      cur_len     <= '0;
      best_len    <= '0;
      test_req    <= 1'b0;
      dly_en      <= 1'b0;
      smp_en      <= 1'b0;
      cfg_unit    <= '0;
      cfg_phase   <= '0;
      final_phase <= '0;
      done        <= 1'b0;
      err         <= 1'b0;
    end else begin
      done <= 1'b0;
      if (bypass) begin
        dly_en   <= 1'b0;
        smp_en   <= 1'b0;
        test_req <= 1'b0;
        fin      <= 1'b0;
        state    <= ST_IDLE;
      end else begin
        case (state)
          ST_IDLE: if (start) begin
            unit_r   <= unit_in;
            max_r    <= max_phase_in;
            phase    <= '0;
            cur_len  <= '0;
            best_len <= '0;
            best_end <= '0;
            fin      <= 1'b0;
            err      <= 1'b0;
            state    <= ST_EN;
          end
          ST_EN: begin
            dly_en <= 1'b1;
            smp_en <= 1'b1;
            state  <= ST_WR;
          end
          ST_WR: begin
            cfg_unit  <= unit_r;
            cfg_phase <= phase;
            state     <= ST_REL;
          end
          ST_REL: begin
            smp_en <= 1'b0;
            if (fin) begin
              fin         <= 1'b0;
              final_phase <= cfg_phase;
              done        <= 1'b1;
              state       <= ST_IDLE;
            end else begin
              test_req <= 1'b1;
              state    <= ST_TEST;
            end
          end
          ST_TEST: if (test_ack) begin
            test_req <= 1'b0;
            if (test_pass) begin
              cur_len <= cur_inc;
              if (cur_inc > best_len) begin
                best_len <= cur_inc;
                best_end <= phase;
              end
            end else begin
              cur_len <= '0;
            end
            if (phase == max_r) begin
              state <= ST_DECIDE;
            end else begin
              phase <= phase + PH_W'(1);
              state <= ST_EN;
            end
          end
          ST_DECIDE: begin
            if (best_len == '0) begin
              err   <= 1'b1;
              done  <= 1'b1;
              state <= ST_IDLE;
            end else begin
              phase <= best_end - PH_W'(best_len >> 1);
              fin   <= 1'b1;
              state <= ST_EN;
            end
          end
          default: state <= ST_IDLE;
        endcase
      end
    end
  end
endmodule

module phase_window_search_chk #(
  parameter int UNIT_W = 7,
  parameter int PH_W   = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bypass,
  input logic              test_ack,
  input logic              test_req,
  input logic              dly_en,
  input logic              smp_en,
  input logic [UNIT_W-1:0] cfg_unit,
  input logic [PH_W-1:0]   cfg_phase,
  input logic              done,
  input logic              err
);
  assert_sampler_with_delay_R3: assert property (@(posedge clk) disable iff (!rst_n)
    smp_en |-> dly_en);
  assert_req_after_release_R3: assert property (@(posedge clk) disable iff (!rst_n)
    test_req |-> (dly_en && !smp_en));
  assert_write_while_sampling_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(cfg_phase) || !$stable(cfg_unit)) |-> smp_en);
  assert_hold_until_ack_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (test_req && !test_ack && !bypass) |=> (test_req && $stable(cfg_phase) && $stable(cfg_unit)));
  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  assert_done_no_req_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !test_req);
  assert_err_with_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err) |-> done);
  assert_bypass_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
    bypass |=> (!dly_en && !smp_en && !test_req && !done));
endmodule

bind phase_window_search phase_window_search_chk #(.UNIT_W(UNIT_W), .PH_W(PH_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .bypass(bypass), .test_ack(test_ack),
  .test_req(test_req), .dly_en(dly_en), .smp_en(smp_en), .cfg_unit(cfg_unit),
  .cfg_phase(cfg_phase), .done(done), .err(err)
);

// File: tb/phase_window_search_tb_top.sv
module phase_window_search_tb_top;
  localparam int UNIT_W = 7;
  localparam int PH_W   = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0, bypass = 1'b0, test_ack = 1'b0, test_pass = 1'b0;
  logic [UNIT_W-1:0] unit_in = '0;
  logic [PH_W-1:0]   max_phase_in = '0;
  logic test_req, dly_en, smp_en, done, err;
  logic [UNIT_W-1:0] cfg_unit;
  logic [PH_W-1:0]   cfg_phase, final_phase;

  int n_tests = 0;
  int n_fail  = 0;

  always #5 clk = ~clk;

  phase_window_search #(.UNIT_W(UNIT_W), .PH_W(PH_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .bypass(bypass),
    .unit_in(unit_in), .max_phase_in(max_phase_in),
    .test_ack(test_ack), .test_pass(test_pass), .test_req(test_req),
    .dly_en(dly_en), .smp_en(smp_en), .cfg_unit(cfg_unit), .cfg_phase(cfg_phase),
    .final_phase(final_phase), .done(done), .err(err)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic void model(input int mx, input logic [15:0] pat,
                                output bit e, output int fp);
    int best = 0;
    int bend = 0;
    for (int s = 0; s <= mx; s++) begin
      if (pat[s] && (s == 0 || !pat[s-1])) begin
        int len = 0;
        while (s + len <= mx && pat[s+len]) len++;
        if (len > best) begin
          best = len;
          bend = s + len - 1;
        end
      end
    end
    e  = (best == 0);
    fp = bend - best / 2;
  endfunction

  task automatic run_search(input int mx, input logic [15:0] pat, input int unit,
                            input int lat, input string tag);
    bit e;
    int fp, idx, cyc;
    bit got;
    model(mx, pat, e, fp);
    @(negedge clk);
    start = 1'b1; unit_in = UNIT_W'(unit); max_phase_in = PH_W'(mx);
    @(negedge clk);
    start = 1'b0; unit_in = '0; max_phase_in = '0;
    idx = 0; got = 0; cyc = 0;
    while (!got && cyc < 3000) begin
      @(negedge clk);
      cyc++;
      test_ack = 1'b0;
      if (done) got = 1;
      else if (test_req) begin
        chk(cfg_phase == PH_W'(idx), "R2 phase order", cfg_phase, idx);
        chk(cfg_unit == UNIT_W'(unit), "R2 unit field", cfg_unit, unit);
        chk(dly_en && !smp_en, "R3 enables at request", {dly_en, smp_en}, 2);
        for (int w = 0; w < lat; w++) begin
          @(negedge clk);
          chk(test_req && cfg_phase == PH_W'(idx), "R3 hold until ack", cfg_phase, idx);
        end
        test_ack = 1'b1;
        test_pass = pat[idx];
        idx++;
      end
    end
    test_ack = 1'b0;
    chk(got, {tag, " R8 done seen"}, got, 1);
    chk(idx == mx + 1, "R2 test count", idx, mx + 1);
    chk(err == e, {tag, " R4 R7 err"}, err, e);
    if (e) begin
      chk(cfg_phase == PH_W'(mx), "R7 no final write", cfg_phase, mx);
    end else begin
      chk(final_phase == PH_W'(fp), {tag, " R4 R6 final_phase"}, final_phase, fp);
      chk(cfg_phase == PH_W'(fp), "R6 cfg_phase", cfg_phase, fp);
      chk(dly_en && !smp_en, "R6 final enables", {dly_en, smp_en}, 2);
    end
    @(negedge clk);
    chk(!done, "R8 single pulse", done, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(!dly_en && !smp_en && !test_req && !done && !err, "R1 reset controls",
        {dly_en, smp_en, test_req, done, err}, 0);
    chk(cfg_phase == 0 && cfg_unit == 0 && final_phase == 0, "R1 reset fields",
        int'(cfg_phase) + int'(cfg_unit) + int'(final_phase), 0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int p = 0; p < 32; p++) run_search(4, 16'(p), p + 3, p % 3, "sweep5");
    run_search(0, 16'h0000, 1, 0, "single");
    run_search(0, 16'h0001, 2, 1, "single");
    run_search(15, 16'hFFFF, 127, 0, "full");
    run_search(15, 16'h7FFE, 9, 1, "inner");
    run_search(15, 16'h0F0F, 5, 0, "R5 tie");
    run_search(15, 16'h8001, 6, 0, "R5 edges");
    run_search(15, 16'h00E7, 7, 2, "R5 tie3");
    run_search(15, 16'h3C06, 8, 0, "R4 longer later");
    run_search(15, 16'h0000, 10, 0, "R7 none");

    @(negedge clk);
    start = 1'b1; unit_in = 7'd4; max_phase_in = 4'd7;
    @(negedge clk);
    start = 1'b0;
    begin
      int n = 0;
      while (n < 2) begin
        @(negedge clk);
        test_ack = 1'b0;
        if (test_req) begin test_ack = 1'b1; test_pass = 1'b1; n++; end
      end
    end
    @(negedge clk);
    test_ack = 1'b0;
    bypass = 1'b1;
    @(negedge clk);
    chk(!dly_en && !smp_en && !test_req, "R9 bypass clears",
        {dly_en, smp_en, test_req}, 0);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    begin
      bit seen = 0;
      for (int k = 0; k < 40; k++) begin
        @(negedge clk);
        if (done || test_req || dly_en) seen = 1;
      end
      chk(!seen, "R9 aborted and start ignored", seen, 0);
    end
    bypass = 1'b0;
    @(negedge clk);
    run_search(4, 16'h001C, 11, 0, "R9 after bypass");

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule